// File: doc/BRIEF.md
# I/O Port Decode Enable Filter

This block decides, for every CPU I/O cycle, whether an on-chip peripheral may answer it and whether the cycle should go out to the expansion bus instead. It keeps two 32-bit enable words. The internal word turns on-chip devices on or off. The expansion word is a second mask that applies only while the expansion bus is active. Software reads and writes each word one byte at a time through numbered 8-bit registers.

For each I/O address, a small decoder raises one hit bit at the word position of the device that owns that port. The block then gives a per-device select and a single forward flag. Both depend only on the address, the strobe and the stored words, and they are valid in the same cycle as the strobe. When the expansion bus is active, a cycle aimed at a device that has been disabled internally is forwarded to the bus. When the bus is off, such a cycle is dropped.

Each cycle, the reset logic picks one of three actions. In RA_NONE, ordinary register writes are applied. In RA_KEEP, a reset was requested but the internal word is held. In RA_FILL, the internal word is set to all ones. The choice depends on the reset kind and on the top bit of the internal word as it stood before the reset.

Top module: `pdf_filter`

## Requirements
- R1: While `rst_n` is low, both words are all ones. After release, every enable register reads 0xFF and `dev_en` is 0xFFFFFFFF.
- R2: Register numbers 0x82, 0x83, 0x84 and 0x85 map to internal word bits 7:0, 15:8, 23:16 and 31:24. Numbers 0x86 to 0x89 map the expansion word in the same way. Every bit is stored as written, including the reserved bits 30:26. Any other register number reads 0x00, and a write to it changes neither word.
- R3: A write with `reg_cop`=1 to a register number above 0x7F is discarded.
- R4: A hard reset request sets the internal word to all ones if internal bit 31 is 0, and leaves the word unchanged if bit 31 is 1.
- R5: A soft reset request, with no hard request in the same cycle, sets the internal word to all ones if internal bit 31 is 1, and leaves the word unchanged if bit 31 is 0.
- R6: When soft and hard requests arrive together, the hard rule of R4 decides. A register write in any cycle with a reset request is discarded. Soft and hard resets never change the expansion word.
- R7: Word bit 24 is hit by ports 0xBF3B and 0xFF3B only. Word bit 25 is hit by every port whose low address byte is 0x0B. No other bit is ever hit.
- R8: `dev_en` equals the internal word when `exp_on`=0, and the internal word ANDed with the expansion word when `exp_on`=1.
- R9: `dev_sel` has a bit set only where `io_strobe`=1, the address hits that bit, and the `dev_en` bit is 1. `dev_sel` is valid in the same cycle as the strobe.
- R10: `exp_fwd` is 1 exactly when `io_strobe`=1, `exp_on`=1, and the address hits a bit whose internal enable is 0. It is never 1 together with any `dev_sel` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Soft reset request, sampled on the clock edge |
| hard_rst | input | 1 | Hard reset request, sampled on the clock edge |
| reg_wr | input | 1 | Register write strobe |
| reg_cop | input | 1 | The write comes from the display-list coprocessor |
| reg_num | input | 8 | Register number for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_num`, combinational |
| io_strobe | input | 1 | An I/O cycle is present |
| io_addr | input | 16 | I/O port address |
| exp_on | input | 1 | The expansion bus is active |
| dev_en | output | 32 | Effective enable per device |
| dev_sel | output | 32 | Device chosen to answer this cycle |
| exp_fwd | output | 1 | Forward this cycle to the expansion bus |

## Verification
The bench uses the default build: four bytes per word, with register bases 0x82 and 0x86. At this size every register number, and every setting of the two decoded enable bits in both words, can be reached directly.

For all 32 combinations of the two internal bits, the two expansion bits and `exp_on`, the bench sweeps all 256 low address bytes under four high bytes. This covers both ports of bit 24, their near misses, and the full class of ports for bit 25.

The reset checks run each rule with bit 31 set and clear, alone and together. They also check that a write made during a reset request is dropped.

// File: rtl/pdf_pkg.sv
package pdf_pkg;
    localparam int BYTES_PER_WORD = 4;
    localparam int WORD_W         = BYTES_PER_WORD * 8;
    localparam int BIT_PALETTE    = 24;
    localparam int BIT_LOW0B      = 25;
    localparam logic [7:0] INT_REG_BASE = 8'h82;
    localparam logic [7:0] EXP_REG_BASE = 8'h86;

    typedef enum logic [1:0] {
        RA_NONE = 2'd0,
        RA_KEEP = 2'd1,
        RA_FILL = 2'd2
    } reset_act_e;
endpackage

// File: rtl/pdf_regfile.sv
module pdf_regfile
    import pdf_pkg::*;
#(
    parameter int         NBYTES   = BYTES_PER_WORD,
    parameter logic [7:0] INT_BASE = INT_REG_BASE,
    parameter logic [7:0] EXP_BASE = EXP_REG_BASE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic                hard_rst,
    input  logic                wr_en,
    input  logic                wr_cop,
    input  logic [7:0]          reg_num,
    input  logic [7:0]          wr_data,
    output logic [7:0]          rd_data,
    output logic [NBYTES*8-1:0] int_word,
    output logic [NBYTES*8-1:0] exp_word
);
    localparam int W = NBYTES * 8;

    logic [W-1:0] int_q, exp_q;
    reset_act_e   act;
    logic         wr_ok;

    // Reset action decision; hard request outranks soft.
    always_comb begin
        if (hard_rst)      act = int_q[W-1] ? RA_KEEP : RA_FILL;
        else if (soft_rst) act = int_q[W-1] ? RA_FILL : RA_KEEP;
        else               act = RA_NONE;
    end

    assign wr_ok = wr_en && !(wr_cop && reg_num[7]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q <= '1;
            exp_q <= '1;
        end else begin
            unique case (act)
                RA_FILL: int_q <= '1;
                RA_KEEP: ;
                RA_NONE: begin
                    for (int b = 0; b < NBYTES; b++) begin
                        if (wr_ok && reg_num == 8'(INT_BASE + b))
                            int_q[b*8 +: 8] <= wr_data;
                        if (wr_ok && reg_num == 8'(EXP_BASE + b))
                            exp_q[b*8 +: 8] <= wr_data;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (reg_num == 8'(INT_BASE + b)) rd_data = int_q[b*8 +: 8];
            if (reg_num == 8'(EXP_BASE + b)) rd_data = exp_q[b*8 +: 8];
        end
    end

    assign int_word = int_q;
    assign exp_word = exp_q;

    AST_HARD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst && !int_q[W-1] |=> int_q == '1); // R4
    AST_HARD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst && int_q[W-1] |=> $stable(int_q)); // R4
    AST_SOFT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst && !hard_rst && int_q[W-1] |=> int_q == '1); // R5
    AST_SOFT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst && !hard_rst && !int_q[W-1] |=> $stable(int_q)); // R5
    AST_EXP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst || hard_rst |=> $stable(exp_q)); // R6
    AST_COP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_cop && reg_num[7] && !soft_rst && !hard_rst
        |=> $stable(int_q) && $stable(exp_q)); // R3
endmodule

// File: rtl/pdf_decoder.sv
module pdf_decoder
    import pdf_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [15:0]  io_addr,
    output logic [W-1:0] hit
);
    always_comb begin
        hit = '0;
        hit[BIT_PALETTE] = (io_addr == 16'hBF3B) || (io_addr == 16'hFF3B);
        hit[BIT_LOW0B]   = (io_addr[7:0] == 8'h0B);
    end
endmodule

// File: rtl/pdf_filter.sv
module pdf_filter
    import pdf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        hard_rst,
    input  logic        reg_wr,
    input  logic        reg_cop,
    input  logic [7:0]  reg_num,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        io_strobe,
    input  logic [15:0] io_addr,
    input  logic        exp_on,
    output logic [31:0] dev_en,
    output logic [31:0] dev_sel,
    output logic        exp_fwd
);
    localparam int W = WORD_W;

    logic [W-1:0] int_word, exp_word, hit;

    pdf_regfile #(
        .NBYTES  (BYTES_PER_WORD),
        .INT_BASE(INT_REG_BASE),
        .EXP_BASE(EXP_REG_BASE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .hard_rst(hard_rst),
        .wr_en   (reg_wr),
        .wr_cop  (reg_cop),
        .reg_num (reg_num),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .int_word(int_word),
        .exp_word(exp_word)
    );

    pdf_decoder #(.W(W)) u_dec (
        .io_addr(io_addr),
        .hit    (hit)
    );

    always_comb begin
        dev_en  = exp_on ? (int_word & exp_word) : int_word;
        dev_sel = io_strobe ? (hit & dev_en) : '0;
        exp_fwd = io_strobe && exp_on && |(hit & ~int_word);
    end

    AST_FWD_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        exp_fwd |-> exp_on && io_strobe); // R10
    AST_SEL_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        !(exp_fwd && |dev_sel)); // R10
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel)); // R7
    AST_SEL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        |dev_sel |-> io_strobe); // R9
endmodule

// File: tb/tb_pdf_filter.sv
module tb_pdf_filter;
    logic        clk = 0;
    logic        rst_n = 0, soft_rst = 0, hard_rst = 0;
    logic        reg_wr = 0, reg_cop = 0, io_strobe = 0, exp_on = 0;
    logic [7:0]  reg_num = 0, reg_wdata = 0, reg_rdata;
    logic [15:0] io_addr = 0;
    logic [31:0] dev_en, dev_sel;
    logic        exp_fwd;
    int          n_chk = 0, n_bad = 0;
    logic [31:0] int_m, exp_m;

    always #5 clk = ~clk;

    pdf_filter dut (.*);

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] num, input logic [7:0] d, input logic cop);
        @(negedge clk);
        reg_wr = 1; reg_num = num; reg_wdata = d; reg_cop = cop;
        @(negedge clk);
        reg_wr = 0; reg_cop = 0;
    endtask

    task automatic rd(input logic [7:0] num, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_num = num;
        #1;
        chk(reg_rdata === exp, tag, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    task automatic pulse(input logic s, input logic h);
        @(negedge clk);
        soft_rst = s; hard_rst = h;
        @(negedge clk);
        soft_rst = 0; hard_rst = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1ms;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(dev_en === 32'hFFFF_FFFF, "R1 dev_en during reset", dev_en, 32'hFFFF_FFFF);
        rst_n = 1;
        for (int r = 8'h82; r <= 8'h89; r++) rd(8'(r), 8'hFF, "R1 reg after power-on");

        // R2 byte mapping and readback
        int_m = 32'h4433_2211; exp_m = 32'h8877_6655;
        for (int b = 0; b < 4; b++) begin
            wr(8'(8'h82 + b), int_m[b*8 +: 8], 0);
            wr(8'(8'h86 + b), exp_m[b*8 +: 8], 0);
        end
        for (int b = 0; b < 4; b++) begin
            rd(8'(8'h82 + b), int_m[b*8 +: 8], "R2 internal byte");
            rd(8'(8'h86 + b), exp_m[b*8 +: 8], "R2 expansion byte");
        end
        @(negedge clk); exp_on = 0; #1;
        chk(dev_en === int_m, "R2 R8 word bit order", dev_en, int_m);
        wr(8'h81, 8'hAA, 0); wr(8'h8A, 8'hAA, 0);
        rd(8'h81, 8'h00, "R2 unmapped 0x81 reads zero");
        rd(8'h8A, 8'h00, "R2 unmapped 0x8A reads zero");
        @(negedge clk); exp_on = 1; #1;
        chk(dev_en === (int_m & exp_m), "R2 unmapped write leaves words", dev_en, int_m & exp_m);
        exp_on = 0;

        // R3 coprocessor writes dropped
        wr(8'h84, 8'h00, 1); wr(8'h88, 8'h00, 1);
        rd(8'h84, int_m[23:16], "R3 cop write internal");
        rd(8'h88, exp_m[23:16], "R3 cop write expansion");

        // R7 R8 R9 R10 sweep
        for (int cfg = 0; cfg < 32; cfg++) begin
            logic i24, i25, e24, e25, bus;
            {bus, e25, e24, i25, i24} = 5'(cfg);
            int_m[31:24] = {6'h3F, i25, i24};
            exp_m[31:24] = {6'h3F, e25, e24};
            wr(8'h85, int_m[31:24], 0);
            wr(8'h89, exp_m[31:24], 0);
            @(negedge clk);
            exp_on = bus;
            for (int hb = 0; hb < 4; hb++) begin
                for (int lb = 0; lb < 256; lb++) begin
                    logic [15:0] a;
                    logic h24, h25;
                    logic [31:0] eff, sel_e;
                    logic fwd_e;
                    a = {(hb == 0) ? 8'h00 : (hb == 1) ? 8'hBF : (hb == 2) ? 8'hFF : 8'h7F, 8'(lb)};
                    h24 = (a == 16'hBF3B) || (a == 16'hFF3B);
                    h25 = (a[7:0] == 8'h0B);
                    eff = bus ? (int_m & exp_m) : int_m;
                    sel_e = 32'h0;
                    sel_e[24] = h24 & eff[24];
                    sel_e[25] = h25 & eff[25];
                    fwd_e = bus & ((h24 & ~i24) | (h25 & ~i25));
                    io_addr = a; io_strobe = 1;
                    #1;
                    chk(dev_sel === sel_e, "R7 R9 dev_sel", dev_sel, sel_e);
                    chk(exp_fwd === fwd_e, "R10 exp_fwd", {31'h0, exp_fwd}, {31'h0, fwd_e});
                    chk(dev_en === eff, "R8 dev_en", dev_en, eff);
                end
            end
            io_addr = 16'hBF3B; io_strobe = 0; #1;
            chk(dev_sel === 0 && exp_fwd === 0, "R9 R10 no strobe", {dev_sel[31:1], exp_fwd}, 0);
        end
        exp_on = 0;

        // R4 hard reset
        wr(8'h85, 8'h7F, 0); wr(8'h82, 8'h00, 0);
        pulse(0, 1);
        rd(8'h82, 8'hFF, "R4 hard fill low byte");
        rd(8'h85, 8'hFF, "R4 hard fill top byte");
        wr(8'h82, 8'h12, 0);
        pulse(0, 1);
        rd(8'h82, 8'h12, "R4 hard keep with bit31 set");

        // R5 soft reset
        wr(8'h82, 8'h34, 0);
        pulse(1, 0);
        rd(8'h82, 8'hFF, "R5 soft fill with bit31 set");
        wr(8'h85, 8'h7F, 0); wr(8'h82, 8'h56, 0);
        pulse(1, 0);
        rd(8'h82, 8'h56, "R5 soft keep with bit31 clear");
        rd(8'h85, 8'h7F, "R5 soft keep top byte");

        // R6 priority, write blocking, expansion untouched
        pulse(1, 1);
        rd(8'h82, 8'hFF, "R6 both with bit31 clear fills");
        wr(8'h82, 8'h9A, 0);
        pulse(1, 1);
        rd(8'h82, 8'h9A, "R6 both with bit31 set keeps");
        @(negedge clk);
        hard_rst = 1; reg_wr = 1; reg_num = 8'h83; reg_wdata = 8'h00;
        @(negedge clk);
        hard_rst = 0; reg_wr = 0;
        rd(8'h83, 8'hFF, "R6 write during reset dropped");
        rd(8'h89, exp_m[31:24], "R6 expansion unchanged by resets");
        rd(8'h86, exp_m[7:0], "R6 expansion low byte unchanged");

        summary();
    end
endmodule